// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the control side of an in-order pipeline with five stages: fetch, two decode stages, execute and writeback. Effective addresses are formed in the second decode stage. Memory reads and writes finish inside execute. The datapath, the instruction-length decoder and the caches are outside the block. The controller keeps a shadow copy of each in-flight instruction's control fields: source and destination register numbers, write enable, branch and address-use flags, slow-decode requests and branch target. From these it derives hold and bubble controls, forwarding selects, flushes and the fetch redirect.

The fetch unit presents one decoded descriptor per cycle on the `in_*` pins. The controller accepts it when `fetch_take` is high. While a branch sits in execute, the controller asks the fetch unit to read the branch target speculatively. If the datapath then reports the branch taken, the controller discards the two younger decode-stage instructions. It also loads the descriptor presented in that same cycle, which the fetch unit has switched to the target instruction, into the first decode stage. Because of this, a taken branch costs three cycles and a not-taken branch costs one.

Top module: `hzd_ctrl`

## Requirements
- R1: After reset, `wb_valid`, `rf_we`, `spec_fetch_req`, `redirect_valid`, `flush_front`, `hold_fetch`, `hold_d1`, `hold_d2` and the three forwarding selects are all 0.
- R2: When an instruction in execute reads operand A (or B) and the instruction directly ahead of it, now in writeback, is valid and writes that register, `fwd_ex_a` (or `fwd_ex_b`) is 1. A value of 1 selects the just-computed result instead of the register file, and no stall is added.
- R3: An address-using instruction that writes a register (a load) forwards to the ALU instruction right behind it through the same path, with no stall.
- R4: An older instruction whose write enable is 0 never drives a forwarding select, even when its destination number matches.
- R5: If the instruction in the second decode stage uses operand A as an address base and the instruction in execute writes that register, the controller holds fetch and both decode stages for exactly one cycle and sends a bubble into execute. In the following cycle `fwd_d2_addr` is 1.
- R6: If the address producer is one instruction further ahead, so it is already in writeback, `fwd_d2_addr` is 1 and no hold occurs.
- R7: In each cycle that a valid branch is in execute, `spec_fetch_req` is 1 and `spec_fetch_addr` equals that branch's target.
- R8: A branch resolved not taken adds no cycles, and it causes no flush and no redirect.
- R9: A taken branch raises `flush_front` and `redirect_valid` for one cycle with `redirect_target` set to its target. The instructions in both decode stages are discarded, and the next useful instruction reaches execute three cycles after the branch did.
- R10: An instruction flagged slow for the first (or second) decode stage spends one extra cycle there. Stages behind it are held during that cycle. Both flags on one instruction add two cycles.
- R11: A taken branch takes priority over every hold in the same cycle. All holds are 0 in that cycle, and execute holds no branch in the next cycle.
- R12: `br_taken` has no effect in any cycle where execute holds no valid branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch presents a descriptor |
| in_src_a | input | REG_W | Operand A register number |
| in_use_a | input | 1 | Operand A is read |
| in_src_b | input | REG_W | Operand B register number |
| in_use_b | input | 1 | Operand B is read |
| in_dst | input | REG_W | Destination register number |
| in_wr | input | 1 | Instruction writes its destination |
| in_branch | input | 1 | Conditional branch or call |
| in_addr_use | input | 1 | Operand A is an address base in decode stage two |
| in_slow_d1 | input | 1 | Needs two cycles in decode stage one |
| in_slow_d2 | input | 1 | Needs two cycles in decode stage two |
| in_target | input | PC_W | Branch target |
| br_taken | input | 1 | Branch outcome for the instruction in execute |
| fetch_take | output | 1 | Presented descriptor is accepted this cycle |
| hold_fetch | output | 1 | Fetch must repeat its current descriptor |
| hold_d1 | output | 1 | Decode stage one keeps its contents |
| hold_d2 | output | 1 | Decode stage two keeps its contents |
| bubble_ex | output | 1 | A bubble enters execute at the next edge |
| flush_front | output | 1 | Both decode stages are discarded |
| redirect_valid | output | 1 | Fetch restarts after the target |
| redirect_target | output | PC_W | Target of the taken branch |
| spec_fetch_req | output | 1 | Read the target speculatively |
| spec_fetch_addr | output | PC_W | Address for the speculative read |
| fwd_ex_a | output | 1 | Execute operand A from the forwarded result |
| fwd_ex_b | output | 1 | Execute operand B from the forwarded result |
| fwd_d2_addr | output | 1 | Address base from the forwarded result |
| wb_valid | output | 1 | Writeback holds a valid instruction |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |

## Verification
A wrong stage register or a stale slow-decode flag shows up at the ports as a retirement that arrives a cycle early or late, or as a wrong order of `rf_waddr` values. The bench therefore records the edge at which the last instruction of each short program retires and compares it with the instruction count plus the penalties the requirements fix. A bad comparison shows up in the same cycle as a forwarding select that is wrong or missing. A flush or redirect error shows up within three cycles as instructions that should not have retired, or as the absence of the target.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef struct packed {
        logic valid;
        logic use_a;
        logic use_b;
        logic wr;
        logic branch;
        logic addr_use;
        logic slow_d1;
        logic slow_d2;
    } stage_flags_t;

    localparam int unsigned HZD_NUM_CMP = 4;

    localparam int unsigned CMP_EX_A   = 0;
    localparam int unsigned CMP_EX_B   = 1;
    localparam int unsigned CMP_D2_WB  = 2;
    localparam int unsigned CMP_D2_EX  = 3;

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int REG_W = 3
) (
    input  logic             need,
    input  logic             prod_ok,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    always_comb begin
        hit = need & prod_ok & (src == dst);
    end
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall (
    input  logic in_valid,
    input  logic d1_valid,
    input  logic d1_slow,
    input  logic d1_done,
    input  logic d2_valid,
    input  logic d2_slow,
    input  logic d2_done,
    input  logic addr_hz,
    input  logic ex_branch,
    input  logic br_taken,
    output logic taken,
    output logic hold_f,
    output logic hold_d1,
    output logic hold_d2,
    output logic take,
    output logic d1_done_d,
    output logic d2_done_d
);
    logic d2_need;
    logic d1_need;

    always_comb begin
        taken     = ex_branch & br_taken;
        d2_need   = (d2_valid & d2_slow & ~d2_done) | addr_hz;
        d1_need   = d1_valid & d1_slow & ~d1_done;
        // a redirect overrides every hold
        hold_d2   = ~taken & d2_need;
        hold_d1   = ~taken & (d2_need | d1_need);
        hold_f    = hold_d1;
        take      = in_valid & ~hold_f;
        d2_done_d = hold_d2 & (d2_done | (d2_valid & d2_slow));
        d1_done_d = hold_d1 & (d1_done | (d1_valid & d1_slow));
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
    parameter int REG_W = 3,
    parameter int PC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] in_src_a,
    input  logic             in_use_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic             in_use_b,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_wr,
    input  logic             in_branch,
    input  logic             in_addr_use,
    input  logic             in_slow_d1,
    input  logic             in_slow_d2,
    input  logic [PC_W-1:0]  in_target,
    input  logic             br_taken,
    output logic             fetch_take,
    output logic             hold_fetch,
    output logic             hold_d1,
    output logic             hold_d2,
    output logic             bubble_ex,
    output logic             flush_front,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_target,
    output logic             spec_fetch_req,
    output logic [PC_W-1:0]  spec_fetch_addr,
    output logic             fwd_ex_a,
    output logic             fwd_ex_b,
    output logic             fwd_d2_addr,
    output logic             wb_valid,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_waddr
);
    import hzd_pkg::*;

    localparam int NCMP = HZD_NUM_CMP;

    typedef struct packed {
        stage_flags_t     f;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;
        logic [PC_W-1:0]  tgt;
    } stage_t;

    typedef struct packed {
        stage_t d1;
        stage_t d2;
        stage_t ex;
        stage_t wb;
        logic   d1_done;
        logic   d2_done;
    } state_t;

    state_t st_q, st_d;
    stage_t in_stage;

    logic [NCMP-1:0]  c_need;
    logic [NCMP-1:0]  c_prod;
    logic [NCMP-1:0]  c_hit;
    logic [REG_W-1:0] c_src [NCMP];
    logic [REG_W-1:0] c_dst [NCMP];

    logic taken, h_f, h_d1, h_d2, take, d1_done_d, d2_done_d;

    // operand comparisons: execute vs writeback, decode-two address vs writeback and execute
    always_comb begin
        c_need[CMP_EX_A]  = st_q.ex.f.valid & st_q.ex.f.use_a;
        c_src [CMP_EX_A]  = st_q.ex.src_a;
        c_prod[CMP_EX_A]  = st_q.wb.f.valid & st_q.wb.f.wr;
        c_dst [CMP_EX_A]  = st_q.wb.dst;
        c_need[CMP_EX_B]  = st_q.ex.f.valid & st_q.ex.f.use_b;
        c_src [CMP_EX_B]  = st_q.ex.src_b;
        c_prod[CMP_EX_B]  = st_q.wb.f.valid & st_q.wb.f.wr;
        c_dst [CMP_EX_B]  = st_q.wb.dst;
        c_need[CMP_D2_WB] = st_q.d2.f.valid & st_q.d2.f.addr_use;
        c_src [CMP_D2_WB] = st_q.d2.src_a;
        c_prod[CMP_D2_WB] = st_q.wb.f.valid & st_q.wb.f.wr;
        c_dst [CMP_D2_WB] = st_q.wb.dst;
        c_need[CMP_D2_EX] = st_q.d2.f.valid & st_q.d2.f.addr_use;
        c_src [CMP_D2_EX] = st_q.d2.src_a;
        c_prod[CMP_D2_EX] = st_q.ex.f.valid & st_q.ex.f.wr;
        c_dst [CMP_D2_EX] = st_q.ex.dst;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        hzd_match #(.REG_W(REG_W)) u_match (
            .need    (c_need[g]),
            .prod_ok (c_prod[g]),
            .src     (c_src[g]),
            .dst     (c_dst[g]),
            .hit     (c_hit[g])
        );
    end

    hzd_stall u_stall (
        .in_valid  (in_valid),
        .d1_valid  (st_q.d1.f.valid),
        .d1_slow   (st_q.d1.f.slow_d1),
        .d1_done   (st_q.d1_done),
        .d2_valid  (st_q.d2.f.valid),
        .d2_slow   (st_q.d2.f.slow_d2),
        .d2_done   (st_q.d2_done),
        .addr_hz   (c_hit[CMP_D2_EX]),
        .ex_branch (st_q.ex.f.valid & st_q.ex.f.branch),
        .br_taken  (br_taken),
        .taken     (taken),
        .hold_f    (h_f),
        .hold_d1   (h_d1),
        .hold_d2   (h_d2),
        .take      (take),
        .d1_done_d (d1_done_d),
        .d2_done_d (d2_done_d)
    );

    always_comb begin
        in_stage            = '0;
        in_stage.f.valid    = in_valid;
        in_stage.f.use_a    = in_use_a;
        in_stage.f.use_b    = in_use_b;
        in_stage.f.wr       = in_wr;
        in_stage.f.branch   = in_branch;
        in_stage.f.addr_use = in_addr_use;
        in_stage.f.slow_d1  = in_slow_d1;
        in_stage.f.slow_d2  = in_slow_d2;
        in_stage.src_a      = in_src_a;
        in_stage.src_b      = in_src_b;
        in_stage.dst        = in_dst;
        in_stage.tgt        = in_target;

        st_d         = st_q;
        st_d.wb      = st_q.ex;
        st_d.ex      = (taken | h_d2) ? '0 : st_q.d2;
        if (taken) begin
            st_d.d2 = '0;
        end else if (h_d2) begin
            st_d.d2 = st_q.d2;
        end else if (h_d1) begin
            st_d.d2 = '0;
        end else begin
            st_d.d2 = st_q.d1;
        end
        if (h_d1) begin
            st_d.d1 = st_q.d1;
        end else if (take) begin
            st_d.d1 = in_stage;
        end else begin
            st_d.d1 = '0;
        end
        st_d.d1_done = d1_done_d;
        st_d.d2_done = d2_done_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fetch_take      = take;
        hold_fetch      = h_f;
        hold_d1         = h_d1;
        hold_d2         = h_d2;
        bubble_ex       = h_d2;
        flush_front     = taken;
        redirect_valid  = taken;
        redirect_target = st_q.ex.tgt;
        spec_fetch_req  = st_q.ex.f.valid & st_q.ex.f.branch;
        spec_fetch_addr = st_q.ex.tgt;
        fwd_ex_a        = c_hit[CMP_EX_A];
        fwd_ex_b        = c_hit[CMP_EX_B];
        fwd_d2_addr     = c_hit[CMP_D2_WB];
        wb_valid        = st_q.wb.f.valid;
        rf_we           = st_q.wb.f.valid & st_q.wb.f.wr;
        rf_waddr        = st_q.wb.dst;
    end
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_d2,
    input logic flush_front,
    input logic redirect_valid,
    input logic spec_fetch_req,
    input logic fwd_ex_a,
    input logic fwd_ex_b,
    input logic fwd_d2_addr,
    input logic wb_valid,
    input logic rf_we
);
    p_flush_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_front |=> wb_valid);

    p_hold_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_d2 |=> ##1 !wb_valid);

    p_redirect_needs_branch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> spec_fetch_req);

    p_ex_clear_after_redirect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !spec_fetch_req);

    p_fwd_a_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ex_a || fwd_ex_b) |-> rf_we);

    p_fwd_d2_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_d2_addr |-> rf_we);
endmodule

bind hzd_ctrl hzd_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold_d2        (hold_d2),
    .flush_front    (flush_front),
    .redirect_valid (redirect_valid),
    .spec_fetch_req (spec_fetch_req),
    .fwd_ex_a       (fwd_ex_a),
    .fwd_ex_b       (fwd_ex_b),
    .fwd_d2_addr    (fwd_d2_addr),
    .wb_valid       (wb_valid),
    .rf_we          (rf_we)
);

// File: tb/hzd_ctrl_test.sv
`timescale 1ns/1ps
module hzd_ctrl_test;
    localparam int REG_W = 3;
    localparam int PC_W  = 8;
    localparam int MAXP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [REG_W-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic in_use_a = 1'b0, in_use_b = 1'b0, in_wr = 1'b0, in_branch = 1'b0;
    logic in_addr_use = 1'b0, in_slow_d1 = 1'b0, in_slow_d2 = 1'b0;
    logic [PC_W-1:0] in_target = '0;
    logic br_taken = 1'b0;
    logic fetch_take, hold_fetch, hold_d1, hold_d2, bubble_ex, flush_front;
    logic redirect_valid, spec_fetch_req, fwd_ex_a, fwd_ex_b, fwd_d2_addr;
    logic wb_valid, rf_we;
    logic [PC_W-1:0] redirect_target, spec_fetch_addr;
    logic [REG_W-1:0] rf_waddr;

    always #10 clk = ~clk;

    hzd_ctrl #(.REG_W(REG_W), .PC_W(PC_W)) uut (.*);

    int checks = 0;
    int errors = 0;

    logic [REG_W-1:0] p_sa [MAXP], p_sb [MAXP], p_dst [MAXP];
    logic p_ua [MAXP], p_ub [MAXP], p_wr [MAXP], p_br [MAXP];
    logic p_ad [MAXP], p_s1 [MAXP], p_s2 [MAXP];
    int   p_tgt [MAXP];

    int ret, last, n_fa, n_fb, n_fd2, n_hd1, n_hd2, n_flush, n_redir, n_spec;
    int spec_addr, redir_tgt, nw;
    int waddr [MAXP];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < MAXP; i++) begin
            p_sa[i] = '0; p_sb[i] = '0; p_dst[i] = '0; p_ua[i] = 0; p_ub[i] = 0;
            p_wr[i] = 0; p_br[i] = 0; p_ad[i] = 0; p_s1[i] = 0; p_s2[i] = 0; p_tgt[i] = 0;
        end
    endtask

    task automatic alu(input int i, input int d, input int sa, input bit ua, input int sb, input bit ub);
        p_dst[i] = d[REG_W-1:0]; p_wr[i] = 1; p_sa[i] = sa[REG_W-1:0]; p_ua[i] = ua;
        p_sb[i] = sb[REG_W-1:0]; p_ub[i] = ub;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; br_taken = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic present(input int pc, input int n);
        if (pc < n) begin
            in_valid = 1; in_src_a = p_sa[pc]; in_use_a = p_ua[pc]; in_src_b = p_sb[pc];
            in_use_b = p_ub[pc]; in_dst = p_dst[pc]; in_wr = p_wr[pc]; in_branch = p_br[pc];
            in_addr_use = p_ad[pc]; in_slow_d1 = p_s1[pc]; in_slow_d2 = p_s2[pc];
            in_target = p_tgt[pc][PC_W-1:0];
        end else begin
            in_valid = 0;
        end
    endtask

    // runs a program from reset; tk = outcome of the branch, frc = hold br_taken high
    task automatic run(input int n, input bit tk, input bit frc);
        int pc, c;
        bit take;
        do_reset();
        pc = 0; c = 0; ret = 0; last = 0; nw = 0;
        n_fa = 0; n_fb = 0; n_fd2 = 0; n_hd1 = 0; n_hd2 = 0; n_flush = 0;
        n_redir = 0; n_spec = 0; spec_addr = -1; redir_tgt = -1;
        repeat (20) begin
            br_taken = frc | (spec_fetch_req & tk);
            if (spec_fetch_req && br_taken) pc = int'(spec_fetch_addr);
            present(pc, n);
            #1;
            take = fetch_take;
            n_fa += int'(fwd_ex_a); n_fb += int'(fwd_ex_b); n_fd2 += int'(fwd_d2_addr);
            n_hd1 += int'(hold_d1); n_hd2 += int'(hold_d2); n_flush += int'(flush_front);
            if (redirect_valid) begin n_redir++; redir_tgt = int'(redirect_target); end
            if (spec_fetch_req) begin n_spec++; spec_addr = int'(spec_fetch_addr); end
            if (flush_front) check(!hold_d1 && !hold_d2 && !hold_fetch, "R11 holds during flush", int'(hold_d2), 0);
            @(posedge clk);
            c++;
            if (take) pc++;
            @(negedge clk);
            if (wb_valid) begin
                ret++; last = c;
                if (rf_we) begin waddr[nw] = int'(rf_waddr); nw++; end
            end
        end
        in_valid = 0; br_taken = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        repeat (2) @(negedge clk);
        check(!wb_valid && !rf_we && !spec_fetch_req && !redirect_valid && !flush_front,
              "R1 reset outputs", int'(wb_valid), 0);
        check(!hold_fetch && !hold_d1 && !hold_d2 && !fwd_ex_a && !fwd_ex_b && !fwd_d2_addr,
              "R1 reset holds", int'(hold_d1), 0);
    endtask

    task automatic t_alu_pair();
        clear_prog(); alu(0, 1, 0, 0, 0, 0); alu(1, 4, 1, 1, 2, 1);
        run(2, 0, 0);
        check(last == 5, "R2 alu pair timing", last, 5);
        check(n_fa == 1 && n_fb == 0, "R2 fwd a only", n_fa * 10 + n_fb, 10);
    endtask

    task automatic t_load_use();
        clear_prog(); alu(0, 2, 6, 1, 0, 0); p_ad[0] = 1; alu(1, 5, 0, 0, 2, 1);
        run(2, 0, 0);
        check(last == 5, "R3 load-use timing", last, 5);
        check(n_fb == 1, "R3 load fwd b", n_fb, 1);
    endtask

    task automatic t_nowrite();
        clear_prog(); alu(0, 1, 0, 0, 0, 0); p_wr[0] = 0; alu(1, 3, 1, 1, 1, 1);
        run(2, 0, 0);
        check(n_fa == 0 && n_fb == 0, "R4 no fwd from non-writer", n_fa + n_fb, 0);
    endtask

    task automatic t_addr_use();
        clear_prog(); alu(0, 3, 0, 0, 0, 0); alu(1, 6, 3, 1, 0, 0); p_ad[1] = 1;
        run(2, 0, 0);
        check(last == 6, "R5 address-use one stall", last, 6);
        check(n_hd2 == 1 && n_hd1 == 1, "R5 hold count", n_hd2, 1);
        check(n_fd2 == 1, "R5 addr forward", n_fd2, 1);
    endtask

    task automatic t_addr_gap();
        clear_prog(); alu(0, 3, 0, 0, 0, 0); alu(1, 5, 0, 0, 0, 0); alu(2, 6, 3, 1, 0, 0); p_ad[2] = 1;
        run(3, 0, 0);
        check(last == 6, "R6 gap no stall", last, 6);
        check(n_hd2 == 0 && n_fd2 == 1, "R6 fwd from wb", n_fd2, 1);
    endtask

    task automatic t_not_taken();
        clear_prog(); p_br[0] = 1; p_tgt[0] = 3;
        alu(1, 1, 0, 0, 0, 0); alu(2, 2, 0, 0, 0, 0); alu(3, 3, 0, 0, 0, 0);
        run(4, 0, 0);
        check(n_spec == 1 && spec_addr == 3, "R7 speculative target", spec_addr, 3);
        check(last == 7 && ret == 4, "R8 not-taken timing", last, 7);
        check(n_flush == 0 && n_redir == 0, "R8 no flush", n_flush, 0);
    endtask

    task automatic t_taken();
        clear_prog(); alu(0, 1, 0, 0, 0, 0); p_br[1] = 1; p_tgt[1] = 5;
        for (int i = 2; i < 7; i++) alu(i, i, 0, 0, 0, 0);
        run(7, 1, 0);
        check(ret == 4 && last == 9, "R9 taken timing", last, 9);
        check(n_flush == 1 && n_redir == 1 && redir_tgt == 5, "R9 redirect target", redir_tgt, 5);
        check(nw == 3 && waddr[0] == 1 && waddr[1] == 5 && waddr[2] == 6, "R9 retire order",
              waddr[1], 5);
    endtask

    task automatic t_slow();
        clear_prog(); alu(0, 1, 0, 0, 0, 0); p_s1[0] = 1; alu(1, 2, 0, 0, 0, 0);
        run(2, 0, 0);
        check(last == 6, "R10 slow decode one", last, 6);
        clear_prog(); alu(0, 1, 0, 0, 0, 0); p_s2[0] = 1; alu(1, 2, 0, 0, 0, 0);
        run(2, 0, 0);
        check(last == 6 && n_hd2 == 1, "R10 slow decode two", last, 6);
        clear_prog(); alu(0, 1, 0, 0, 0, 0); p_s1[0] = 1; p_s2[0] = 1; alu(1, 2, 0, 0, 0, 0);
        run(2, 0, 0);
        check(last == 7 && ret == 2, "R10 both slow", last, 7);
    endtask

    task automatic t_flush_prio();
        clear_prog(); alu(0, 4, 0, 0, 0, 0); p_br[0] = 1; p_tgt[0] = 3;
        alu(1, 1, 4, 1, 0, 0); p_ad[1] = 1; alu(2, 2, 0, 0, 0, 0); alu(3, 7, 0, 0, 0, 0);
        run(4, 1, 0);
        check(n_hd2 == 0, "R11 flush beats address stall", n_hd2, 0);
        check(ret == 2 && last == 7 && waddr[1] == 7, "R11 target after flush", last, 7);
    endtask

    task automatic t_ignore();
        clear_prog(); alu(0, 1, 0, 0, 0, 0); alu(1, 4, 1, 1, 0, 0);
        run(2, 0, 1);
        check(n_redir == 0 && n_flush == 0, "R12 stray taken ignored", n_redir, 0);
        check(ret == 2 && last == 5, "R12 timing unchanged", last, 5);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_alu_pair();
        t_load_use();
        t_nowrite();
        t_addr_use();
        t_addr_gap();
        t_not_taken();
        t_taken();
        t_slow();
        t_flush_prio();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule